// File: doc/BRIEF.md
# UART Register Front-End with DMA Handshake

This block is the register-facing side of a UART. A processor reaches it through a simple valid/ready register port. It keeps a control register, a status register, a FIFO-status register, a stored baud divisor and a single receive holding register. Bytes from the receiver arrive on a byte-stream input. Bytes for the transmitter leave on a byte-stream output. The bit-level line logic and the baud generator sit outside the block, and the divisor value is only stored for them.

Each direction has its own two-bit service-mode field. The field can switch the direction off, or serve it through an interrupt pulse, or through a request line to one of two DMA channels. A transmit write goes to one of three aliases, which send one, two or four bytes, least significant first. While a multi-byte write is being sent, the register port withholds its response until the last byte has been taken.

Top module: `uart_regfront`

## Requirements
- R1: After reset every register reads zero and `rx_in_ready`, `tx_valid`, `rx_irq`, `tx_irq` and `dma_req` are all low.
- R2: A received byte is accepted (`rx_in_ready` high) only when the receive mode (control bits [1:0]) is not 0 and status bit 5 (data ready) is clear. A byte held in the register is never overwritten.
- R3: Accepting a byte sets status bit 5 (status at address 0x1 reads 0x20). It also sets FIFO-status bits [2:0] to 1 (address 0x2 reads 0x1).
- R4: When the receive mode is 1, accepting a byte raises `rx_irq` for exactly one cycle, one cycle after the acceptance edge. No pulse occurs in the other modes.
- R5: A read of the receive aliases at 0x4 (byte), 0x5 (halfword) or 0x6 (word) returns the held byte zero-extended. The read clears status bit 5 and FIFO-status bits [2:0].
- R6: When the transmit mode (control bits [3:2]) is not 0, a write to address 0x8 emits bits [7:0]. A write to 0x9 emits 2 bytes and a write to 0xA emits 4 bytes, least significant byte first. `bus_ready` is held low until the last byte is accepted on `tx_valid`/`tx_ready`.
- R7: With transmit mode 0, a transmit write completes at once and emits no byte.
- R8: When the transmit mode is 1, `tx_irq` pulses for one cycle, one cycle after the last byte of a write is accepted. No pulse occurs in the other modes.
- R9: `dma_req[n]` is high when the receive mode equals 2+n and status bit 5 is set. It is also high whenever the transmit mode equals 2+n.
- R10: The control register (0x0, 8 bits) and the divisor register (0x3, 16 bits) read back what was written. Writes to status and FIFO-status have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_valid | input | 1 | Register access request |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Register index |
| bus_wdata | input | 32 | Write data |
| bus_ready | output | 1 | Access completes this cycle |
| bus_rdata | output | 32 | Read data, valid with bus_ready |
| rx_in_valid | input | 1 | Received byte offered |
| rx_in_data | input | 8 | Received byte |
| rx_in_ready | output | 1 | Received byte accepted |
| tx_valid | output | 1 | Transmit byte offered |
| tx_data | output | 8 | Transmit byte |
| tx_ready | input | 1 | Transmit byte taken |
| rx_irq | output | 1 | Receive interrupt pulse |
| tx_irq | output | 1 | Transmit interrupt pulse |
| dma_req | output | 2 | Per-channel DMA request |

## Verification
The hardest case to reach from the ports is a four-byte transmit write that stalls mid-stream. In that case the bus response, the byte order and the interrupt timing all have to line up across several stall cycles. The bench gets there with a sink that drops `tx_ready` on every third cycle, so the write spends cycles waiting between bytes, and it counts the cycles the bus access took. A second hard case is a byte offered while the holding register is full. The bench holds a second byte valid for several cycles before it reads the first, and it confirms that the first byte survives.

// File: rtl/uart_regfront_pkg.sv
// Package: shared register indices and service-mode encoding for the
// UART register front-end. Assumes a 4-bit register index on the bus.
package uart_regfront_pkg;

    typedef enum logic [1:0] {
        MODE_OFF  = 2'd0,
        MODE_IRQ  = 2'd1,
        MODE_DMA0 = 2'd2,
        MODE_DMA1 = 2'd3
    } svc_mode_t;

    localparam logic [3:0] REG_CTRL  = 4'h0;
    localparam logic [3:0] REG_STAT  = 4'h1;
    localparam logic [3:0] REG_FSTAT = 4'h2;
    localparam logic [3:0] REG_DIV   = 4'h3;
    localparam logic [3:0] REG_RXB   = 4'h4;
    localparam logic [3:0] REG_RXH   = 4'h5;
    localparam logic [3:0] REG_RXW   = 4'h6;
    localparam logic [3:0] REG_TXB   = 4'h8;
    localparam logic [3:0] REG_TXH   = 4'h9;
    localparam logic [3:0] REG_TXW   = 4'hA;

    localparam int STAT_RDY_BIT = 5;

endpackage

// File: rtl/uart_rx_hold.sv
// Receive holding stage: keeps one byte plus its data-ready flag.
// Accepts a new byte only when the mode is not off and the flag is clear;
// a read strobe empties it. Assumes clear and accept never coincide.
module uart_rx_hold
    import uart_regfront_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  svc_mode_t  mode,
    input  logic       in_valid,
    input  logic [7:0] in_data,
    output logic       in_ready,
    input  logic       clear,
    output logic       data_rdy,
    output logic [7:0] held_byte,
    output logic       irq
);

    logic accept;

    assign in_ready = (mode != MODE_OFF) && !data_rdy;
    assign accept   = in_valid && in_ready;

    // Hold the byte and the data-ready flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_rdy  <= 1'b0;
            held_byte <= '0;
        end else if (accept) begin
            data_rdy  <= 1'b1;
            held_byte <= in_data;
        end else if (clear) begin
            data_rdy  <= 1'b0;
        end
    end

    // One-cycle interrupt pulse for each byte taken in interrupt mode.
    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= accept && (mode == MODE_IRQ);
    end

endmodule

// File: rtl/uart_tx_serializer.sv
// Transmit serializer: loads a word and a byte count, then offers the
// bytes least significant first on a valid/ready stream. Flags the
// cycle in which its last byte is taken. Assumes start only while idle.
module uart_tx_serializer #(
    parameter int DATA_W = 32,
    localparam int NBYTES = DATA_W / 8,
    localparam int CNT_W  = $clog2(NBYTES) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DATA_W-1:0] load_data,
    input  logic [CNT_W-1:0]  load_bytes,
    output logic              busy,
    output logic              out_valid,
    output logic [7:0]        out_data,
    input  logic              out_ready,
    output logic              last_xfer
);

    logic [DATA_W-1:0] shreg;
    logic [CNT_W-1:0]  remain;
    logic              xfer;

    assign out_valid = busy;
    assign out_data  = shreg[7:0];
    assign xfer      = busy && out_ready;
    assign last_xfer = xfer && (remain == CNT_W'(1));

    // Load on start, shift one byte out per accepted transfer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            shreg  <= '0;
            remain <= '0;
        end else if (start) begin
            busy   <= 1'b1;
            shreg  <= load_data;
            remain <= load_bytes;
        end else if (xfer) begin
            shreg  <= shreg >> 8;
            remain <= remain - CNT_W'(1);
            if (remain == CNT_W'(1)) busy <= 1'b0;
        end
    end

endmodule

// File: rtl/uart_dma_req.sv
// DMA request generator: one request line per channel, raised for receive
// when that channel serves receive and data is held, and for transmit
// whenever that channel serves transmit. Channel n uses mode code 2+n.
module uart_dma_req
    import uart_regfront_pkg::*;
#(
    parameter int NUM_CH = 2
) (
    input  svc_mode_t         rx_mode,
    input  svc_mode_t         tx_mode,
    input  logic              rx_rdy,
    output logic [NUM_CH-1:0] req
);

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        localparam logic [1:0] SEL = 2'(2 + ch);
        // Combine the receive and transmit demands for this channel.
        always_comb begin
            req[ch] = ((rx_mode == svc_mode_t'(SEL)) && rx_rdy) ||
                      (tx_mode == svc_mode_t'(SEL));
        end
    end

endmodule

// File: rtl/uart_regfront.sv
// UART register front-end: decodes the register port, stores control and
// divisor, and routes receive/transmit service to interrupts or DMA
// requests. Assumes the master holds its request until bus_ready.
module uart_regfront
    import uart_regfront_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32,
    parameter int CTRL_W = 8,
    parameter int DIV_W  = 16,
    parameter int NUM_CH = 2,
    localparam int CNT_W = $clog2(DATA_W / 8) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic              bus_ready,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              rx_in_valid,
    input  logic [7:0]        rx_in_data,
    output logic              rx_in_ready,
    output logic              tx_valid,
    output logic [7:0]        tx_data,
    input  logic              tx_ready,
    output logic              rx_irq,
    output logic              tx_irq,
    output logic [NUM_CH-1:0] dma_req
);

    logic [CTRL_W-1:0] ctrl_q;
    logic [DIV_W-1:0]  div_q;
    svc_mode_t         rx_mode, tx_mode;
    logic              rx_rdy;
    logic [7:0]        rx_byte;
    logic              rd_acc, wr_acc, rx_hit, tx_hit;
    logic              tx_start, tx_busy, tx_last;
    logic [CNT_W-1:0]  tx_nbytes;
    logic              tx_irq_q;

    assign rx_mode = svc_mode_t'(ctrl_q[1:0]);
    assign tx_mode = svc_mode_t'(ctrl_q[3:2]);
    assign rd_acc  = bus_valid && !bus_write;
    assign wr_acc  = bus_valid && bus_write;

    // Classify the current address into alias groups and byte counts.
    always_comb begin
        rx_hit    = 1'b0;
        tx_hit    = 1'b0;
        tx_nbytes = CNT_W'(1);
        unique case (4'(bus_addr))
            REG_RXB, REG_RXH, REG_RXW: rx_hit = 1'b1;
            REG_TXB: tx_hit = 1'b1;
            REG_TXH: begin tx_hit = 1'b1; tx_nbytes = CNT_W'(2); end
            REG_TXW: begin tx_hit = 1'b1; tx_nbytes = CNT_W'(4); end
            default: ;
        endcase
    end

    assign tx_start = wr_acc && tx_hit && (tx_mode != MODE_OFF) && !tx_busy;

    // Response: a live transmit write waits for its last byte.
    always_comb begin
        if (wr_acc && tx_hit && (tx_mode != MODE_OFF)) bus_ready = tx_last;
        else                                           bus_ready = 1'b1;
    end

    // Read data multiplexer.
    always_comb begin
        bus_rdata = '0;
        unique case (4'(bus_addr))
            REG_CTRL:  bus_rdata = DATA_W'(ctrl_q);
            REG_STAT:  bus_rdata[STAT_RDY_BIT] = rx_rdy;
            REG_FSTAT: bus_rdata[2:0] = {2'b00, rx_rdy};
            REG_DIV:   bus_rdata = DATA_W'(div_q);
            REG_RXB, REG_RXH, REG_RXW: bus_rdata = DATA_W'(rx_byte);
            default: ;
        endcase
    end

    // Writable configuration registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            div_q  <= '0;
        end else if (wr_acc) begin
            if (4'(bus_addr) == REG_CTRL) ctrl_q <= bus_wdata[CTRL_W-1:0];
            if (4'(bus_addr) == REG_DIV)  div_q  <= bus_wdata[DIV_W-1:0];
        end
    end

    // Transmit interrupt after the final byte of a write in interrupt mode.
    always_ff @(posedge clk) begin
        if (!rst_n) tx_irq_q <= 1'b0;
        else        tx_irq_q <= tx_last && (tx_mode == MODE_IRQ);
    end
    assign tx_irq = tx_irq_q;

    uart_rx_hold u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode      (rx_mode),
        .in_valid  (rx_in_valid),
        .in_data   (rx_in_data),
        .in_ready  (rx_in_ready),
        .clear     (rd_acc && rx_hit),
        .data_rdy  (rx_rdy),
        .held_byte (rx_byte),
        .irq       (rx_irq)
    );

    uart_tx_serializer #(.DATA_W(DATA_W)) u_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (tx_start),
        .load_data  (bus_wdata),
        .load_bytes (tx_nbytes),
        .busy       (tx_busy),
        .out_valid  (tx_valid),
        .out_data   (tx_data),
        .out_ready  (tx_ready),
        .last_xfer  (tx_last)
    );

    uart_dma_req #(.NUM_CH(NUM_CH)) u_dma (
        .rx_mode (rx_mode),
        .tx_mode (tx_mode),
        .rx_rdy  (rx_rdy),
        .req     (dma_req)
    );

endmodule

// File: rtl/uart_regfront_checker.sv
// Checker: temporal properties of the UART register front-end, bound to
// every instance of the top module. Assumes synchronous active-low reset.
module uart_regfront_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       bus_valid,
    input logic       bus_write,
    input logic [3:0] bus_addr,
    input logic       bus_ready,
    input logic       rx_in_valid,
    input logic       rx_in_ready,
    input logic       tx_valid,
    input logic [7:0] tx_data,
    input logic       tx_ready,
    input logic       rx_irq,
    input logic       tx_irq,
    input logic       rx_rdy,
    input logic [7:0] ctrl_q
);

    logic rx_read, tx_wr;
    assign rx_read = bus_valid && !bus_write && (bus_addr inside {4'h4, 4'h5, 4'h6});
    assign tx_wr   = bus_valid && bus_write && (bus_addr inside {4'h8, 4'h9, 4'hA});

    assert_rx_accept_sets_ready_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_in_valid && rx_in_ready) |=> rx_rdy);

    assert_rx_held_kept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_rdy && !rx_read) |=> rx_rdy);

    assert_rx_irq_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rx_irq |-> $past(rx_in_valid && rx_in_ready));

    assert_tx_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

    assert_tx_resp_last_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_wr && bus_ready && (ctrl_q[3:2] != 2'd0)) |-> (tx_valid && tx_ready));

    assert_tx_off_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((ctrl_q[3:2] == 2'd0) && !tx_valid) |=> !tx_valid);

    assert_tx_irq_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        tx_irq |-> $past(tx_valid && tx_ready));

endmodule

bind uart_regfront uart_regfront_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_valid   (bus_valid),
    .bus_write   (bus_write),
    .bus_addr    (4'(bus_addr)),
    .bus_ready   (bus_ready),
    .rx_in_valid (rx_in_valid),
    .rx_in_ready (rx_in_ready),
    .tx_valid    (tx_valid),
    .tx_data     (tx_data),
    .tx_ready    (tx_ready),
    .rx_irq      (rx_irq),
    .tx_irq      (tx_irq),
    .rx_rdy      (rx_rdy),
    .ctrl_q      (8'(ctrl_q))
);

// File: tb/uart_regfront_test.sv
// Directed bench for the UART register front-end: one task per scenario,
// each checking its own results against values derived from the brief.
module uart_regfront_test;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0, bus_write = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_ready;
    logic [31:0] bus_rdata;
    logic        rx_in_valid = 1'b0;
    logic [7:0]  rx_in_data = '0;
    logic        rx_in_ready;
    logic        tx_valid;
    logic [7:0]  tx_data;
    logic        tx_ready = 1'b0;
    logic        rx_irq, tx_irq;
    logic [1:0]  dma_req;

    int checks = 0, errors = 0;
    int rx_irq_cnt = 0, tx_irq_cnt = 0;
    logic [7:0] sink_q[$];
    bit sink_stall = 1'b0;
    int sink_tick = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    uart_regfront uut (
        .clk(clk), .rst_n(rst_n),
        .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_ready(bus_ready), .bus_rdata(bus_rdata),
        .rx_in_valid(rx_in_valid), .rx_in_data(rx_in_data), .rx_in_ready(rx_in_ready),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
        .rx_irq(rx_irq), .tx_irq(tx_irq), .dma_req(dma_req)
    );

    // Transmit sink and interrupt counters, evaluated away from the active edge.
    always @(negedge clk) begin
        logic rdy;
        sink_tick++;
        rdy = sink_stall ? (sink_tick % 3 != 0) : 1'b1;
        tx_ready = rdy;
        if (tx_valid && rdy) sink_q.push_back(tx_data);
        if (rx_irq) rx_irq_cnt++;
        if (tx_irq) tx_irq_cnt++;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic bus_xfer(input logic we, input logic [3:0] addr, input logic [31:0] wd,
                            output logic [31:0] rd, output int cyc);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = we; bus_addr = addr; bus_wdata = wd;
        cyc = 0;
        forever begin
            #1;
            cyc++;
            if (bus_ready) begin rd = bus_rdata; break; end
            if (cyc > 1000) begin
                chk("watchdog bus", 32'(cyc), 0);
                rd = '0;
                break;
            end
            @(negedge clk);
        end
        @(posedge clk);
        #1 bus_valid = 1'b0;
    endtask

    task automatic wr(input logic [3:0] addr, input logic [31:0] wd);
        logic [31:0] rd; int c;
        bus_xfer(1'b1, addr, wd, rd, c);
    endtask

    task automatic rd_chk(input string req, input logic [3:0] addr, input logic [31:0] exp);
        logic [31:0] rd; int c;
        bus_xfer(1'b0, addr, '0, rd, c);
        chk(req, rd, exp);
    endtask

    task automatic rx_push(input logic [7:0] b);
        int n = 0;
        @(negedge clk);
        rx_in_valid = 1'b1; rx_in_data = b;
        forever begin
            #1;
            if (rx_in_ready) break;
            if (++n > 1000) begin chk("watchdog rx", 32'(n), 0); break; end
            @(negedge clk);
        end
        @(posedge clk);
        #1 rx_in_valid = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        #1;
        chk("R1 rx_in_ready", 32'(rx_in_ready), 0);
        chk("R1 tx_valid", 32'(tx_valid), 0);
        chk("R1 irqs", 32'({rx_irq, tx_irq}), 0);
        chk("R1 dma_req", 32'(dma_req), 0);
        rd_chk("R1 ctrl", 4'h0, 0);
        rd_chk("R1 status", 4'h1, 0);
        rd_chk("R1 fstatus", 4'h2, 0);
        rd_chk("R1 divisor", 4'h3, 0);
    endtask

    task automatic t_regs();
        wr(4'h3, 32'hFFFF_1234);
        rd_chk("R10 divisor", 4'h3, 32'h1234);
        wr(4'h0, 32'h0000_01F0);
        rd_chk("R10 ctrl", 4'h0, 32'hF0);
        wr(4'h1, 32'hFFFF_FFFF);
        wr(4'h2, 32'hFFFF_FFFF);
        rd_chk("R10 status write ignored", 4'h1, 0);
        rd_chk("R10 fstatus write ignored", 4'h2, 0);
        wr(4'h0, 0);
    endtask

    task automatic t_rx_irq();
        int base;
        wr(4'h0, 0);
        #1 chk("R2 off mode not ready", 32'(rx_in_ready), 0);
        wr(4'h0, 32'h1);
        base = rx_irq_cnt;
        rx_push(8'hA5);
        chk("R4 one rx irq", 32'(rx_irq_cnt - base), 1);
        rd_chk("R3 status rdy", 4'h1, 32'h20);
        rd_chk("R3 fstatus", 4'h2, 32'h1);
        @(negedge clk);
        rx_in_valid = 1'b1; rx_in_data = 8'h5A;
        for (int i = 0; i < 5; i++) begin
            #1 chk("R2 full not ready", 32'(rx_in_ready), 0);
            @(negedge clk);
        end
        rx_in_valid = 1'b0;
        rd_chk("R5 byte alias", 4'h4, 32'hA5);
        rd_chk("R5 status cleared", 4'h1, 0);
        rd_chk("R5 fstatus cleared", 4'h2, 0);
        rx_push(8'h3C);
        rd_chk("R5 word alias", 4'h6, 32'h3C);
        rx_push(8'hC3);
        rd_chk("R5 half alias", 4'h5, 32'hC3);
        rd_chk("R5 half clears", 4'h1, 0);
        chk("R4 irq per byte", 32'(rx_irq_cnt - base), 3);
    endtask

    task automatic t_rx_dma();
        int base = rx_irq_cnt;
        wr(4'h0, 32'h2);
        #1 chk("R9 rx ch0 idle", 32'(dma_req), 0);
        rx_push(8'h11);
        chk("R9 rx ch0 req", 32'(dma_req), 2'b01);
        chk("R4 no irq in dma mode", 32'(rx_irq_cnt - base), 0);
        rd_chk("R5 dma read", 4'h4, 32'h11);
        #1 chk("R9 rx ch0 drop", 32'(dma_req), 0);
        wr(4'h0, 32'h3);
        rx_push(8'h22);
        chk("R9 rx ch1 req", 32'(dma_req), 2'b10);
        rd_chk("R5 dma ch1 read", 4'h4, 32'h22);
    endtask

    task automatic t_tx_irq();
        logic [31:0] rd; int cyc, base;
        wr(4'h0, 32'h4);
        sink_q.delete();
        base = tx_irq_cnt;
        sink_stall = 1'b1;
        bus_xfer(1'b1, 4'hA, 32'h4433_2211, rd, cyc);
        sink_stall = 1'b0;
        idle(2);
        chk("R6 word count", 32'(sink_q.size()), 4);
        if (sink_q.size() == 4)
            chk("R6 word order", {sink_q[3], sink_q[2], sink_q[1], sink_q[0]}, 32'h4433_2211);
        chk("R6 stall length", 32'(cyc >= 5), 1);
        chk("R8 tx irq once", 32'(tx_irq_cnt - base), 1);
        sink_q.delete();
        wr(4'h9, 32'hAAAA_BEEF);
        idle(2);
        chk("R6 half count", 32'(sink_q.size()), 2);
        if (sink_q.size() == 2) chk("R6 half order", {sink_q[1], sink_q[0]}, 32'hBEEF);
        sink_q.delete();
        wr(4'h8, 32'h1234_567E);
        idle(2);
        chk("R6 byte count", 32'(sink_q.size()), 1);
        if (sink_q.size() == 1) chk("R6 byte value", 32'(sink_q[0]), 32'h7E);
        chk("R8 irq per write", 32'(tx_irq_cnt - base), 3);
    endtask

    task automatic t_tx_off();
        logic [31:0] rd; int cyc, base = tx_irq_cnt;
        wr(4'h0, 0);
        sink_q.delete();
        bus_xfer(1'b1, 4'hA, 32'hDEAD_BEEF, rd, cyc);
        idle(10);
        chk("R7 no bytes", 32'(sink_q.size()), 0);
        chk("R7 immediate", 32'(cyc), 1);
        chk("R7 no irq", 32'(tx_irq_cnt - base), 0);
    endtask

    task automatic t_tx_dma();
        int base = tx_irq_cnt;
        wr(4'h0, 32'h8);
        #1 chk("R9 tx ch0", 32'(dma_req), 2'b01);
        sink_q.delete();
        wr(4'h9, 32'h0000_0102);
        idle(2);
        chk("R6 dma tx bytes", 32'(sink_q.size()), 2);
        chk("R8 no irq in dma", 32'(tx_irq_cnt - base), 0);
        wr(4'h0, 32'hC);
        #1 chk("R9 tx ch1", 32'(dma_req), 2'b10);
        wr(4'h0, 32'hE);
        #1 chk("R9 rx ch0 empty tx ch1", 32'(dma_req), 2'b10);
        rx_push(8'h44);
        chk("R9 both channels", 32'(dma_req), 2'b11);
        rd_chk("R5 final read", 4'h4, 32'h44);
    endtask

    initial begin
        fork
            begin
                repeat (4) @(negedge clk);
                rst_n = 1'b1;
                t_reset();
                t_regs();
                t_rx_irq();
                t_rx_dma();
                t_tx_irq();
                t_tx_off();
                t_tx_dma();
            end
            begin
                repeat (100000) @(posedge clk);
                chk("watchdog expired", 1, 0);
            end
        join_any
        disable fork;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule